// File: doc/BRIEF.md
# Serial memory write-protection unit

This block holds the protection state of a serial memory's status register: a write-enable latch, a two-bit array protection level, and a protect-enable bit. These combine with an external active-low write-protect pin to decide whether a status write or an array write may proceed. A command decoder upstream presents one decoded command per cycle, with an address and a data byte. The unit answers in the same cycle with a grant for the status register or for the addressed array location. Its own state changes at the next clock edge.

The array is split into four equal segments. The protection level selects how many of the top segments are read-only. Hardware protection is on when the protect-enable bit is set and the pin is held low. While it is on, the status register is frozen, so the protect-enable bit cannot be cleared until the pin is released. The status byte is always available for readback.

Top module: `wprot_unit`

## Requirements
- R1: After reset, the status byte shows the protect-enable bit at WPEN_INIT, the level at BP_INIT, and the latch cleared. With the bench configuration (BP_INIT=01, WPEN_INIT=0) this reads 8'h04.
- R2: Command code 1 (write-enable) sets the latch, which is status bit 1. Command code 2 (write-disable) clears it.
- R3: The latch is clear in the cycle after any status write (code 3) or array write (code 4), whether or not that write was granted.
- R4: While the latch is clear, no status or array write is granted.
- R5: The array segment is the top two address bits. Level 0 protects nothing, level 1 protects segment 3, level 2 protects segments 2 and 3, and level 3 protects all segments. An array write to a protected segment is never granted. For a 14-bit address, level 1 covers 0x3000–0x3FFF and level 2 covers 0x2000–0x3FFF.
- R6: Hardware protection is on exactly when the protect-enable bit is 1 and wp_n is 0. While it is on, a status write is refused. While it is off and the latch is set, a status write is granted.
- R7: Hardware protection has no effect on array writes. With the latch set, writes to unprotected segments are still granted.
- R8: A granted status write loads the protect-enable bit from data bit 7 and the level from data bits 3:2. Data bits 6:4 and 1:0 are ignored.
- R9: While wp_n is 0 and the protect-enable bit is 1, that bit stays 1. Once wp_n returns to 1, a granted status write can clear it.
- R10: Grants appear combinationally in the cycle the command is valid, and state changes are visible one cycle later. With cmd_valid low, or with codes 0, 5, 6 or 7, nothing is granted and the state is unchanged.
- R11: Status bits 6:4 and bit 0 (ready, active-low busy) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code: 1 write-enable, 2 write-disable, 3 status write, 4 array write |
| cmd_addr | input | ADDR_W | Array byte address for an array write |
| cmd_data | input | 8 | New status value for a status write |
| wp_n | input | 1 | External write-protect pin, active low |
| sr_write_ok | output | 1 | The status write this cycle is granted |
| mem_write_ok | output | 1 | The array write this cycle is granted |
| status_byte | output | 8 | {prot_en, 3'b000, level[1:0], latch, 1'b0} |

## Verification
Two things can happen in the same cycle: the write-protect pin can change, and a status write can arrive. The pin is therefore driven at the same clock phase as the status-write command, and the grant is judged from the pin value in that cycle, not the one before. The latch clearing also coincides with the grant decision that depends on it. The bench reads the grant while the latch is still set, and reads the cleared latch one edge later. Each outcome is compared with a model built from the requirements, across every combination of level, protect-enable bit, pin and latch, and at both edges of every segment.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WREN  = 3'd1,
        OP_WRDI  = 3'd2,
        OP_WRSR  = 3'd3,
        OP_WRMEM = 3'd4
    } wp_op_e;

    typedef struct packed {
        logic       wel;
        logic       prot_en;
        logic [1:0] level;
    } wp_state_t;

    localparam int SR_PROT_EN_BIT = 7;
    localparam int SR_LEVEL_LSB   = 2;
    localparam int SEG_COUNT      = 4;
endpackage

// File: rtl/wprot_range.sv
module wprot_range #(
    parameter int SEG_BITS = 2
) (
    input  logic [1:0]          level,
    input  logic [SEG_BITS-1:0] seg,
    output logic                blocked
);
    localparam int SEGS = 1 << SEG_BITS;

    logic [SEG_BITS:0] first_locked;

    always_comb begin
        unique case (level)
            2'd0:    first_locked = (SEG_BITS+1)'(SEGS);
            2'd1:    first_locked = (SEG_BITS+1)'(SEGS - SEGS/4);
            2'd2:    first_locked = (SEG_BITS+1)'(SEGS - SEGS/2);
            default: first_locked = '0;
        endcase
        blocked = ({1'b0, seg} >= first_locked);
    end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate (
    input  logic wel,
    input  logic prot_en,
    input  logic wp_n,
    input  logic blocked,
    output logic hw_lock,
    output logic sr_allow,
    output logic mem_allow
);
    always_comb begin
        hw_lock   = prot_en & ~wp_n;
        sr_allow  = wel & ~hw_lock;
        mem_allow = wel & ~blocked;
    end
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit #(
    parameter int         ADDR_W    = 14,
    parameter logic [1:0] BP_INIT   = 2'b00,
    parameter logic       WPEN_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    output logic              sr_write_ok,
    output logic              mem_write_ok,
    output logic [7:0]        status_byte
);
    import wprot_pkg::*;

    localparam int SEG_BITS = $clog2(SEG_COUNT);

    wp_state_t st_q, st_d;
    wp_op_e    op;
    logic      is_wren, is_wrdi, is_wrsr, is_wrmem;
    logic      blocked, hw_lock, sr_allow, mem_allow;

    assign op = wp_op_e'(cmd_op);

    wprot_range #(.SEG_BITS(SEG_BITS)) u_range (
        .level   (st_q.level),
        .seg     (cmd_addr[ADDR_W-1 -: SEG_BITS]),
        .blocked (blocked)
    );

    wprot_gate u_gate (
        .wel       (st_q.wel),
        .prot_en   (st_q.prot_en),
        .wp_n      (wp_n),
        .blocked   (blocked),
        .hw_lock   (hw_lock),
        .sr_allow  (sr_allow),
        .mem_allow (mem_allow)
    );

    always_comb begin
        is_wren  = cmd_valid && (op == OP_WREN);
        is_wrdi  = cmd_valid && (op == OP_WRDI);
        is_wrsr  = cmd_valid && (op == OP_WRSR);
        is_wrmem = cmd_valid && (op == OP_WRMEM);

        sr_write_ok  = is_wrsr && sr_allow;
        mem_write_ok = is_wrmem && mem_allow;

        st_d = st_q;
        if (is_wren)
            st_d.wel = 1'b1;
        if (is_wrdi || is_wrsr || is_wrmem)
            st_d.wel = 1'b0;
        if (sr_write_ok) begin
            st_d.prot_en = cmd_data[SR_PROT_EN_BIT];
            st_d.level   = cmd_data[SR_LEVEL_LSB +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wel     <= 1'b0;
            st_q.prot_en <= WPEN_INIT;
            st_q.level   <= BP_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_byte = {st_q.prot_en, 3'b000, st_q.level, st_q.wel, 1'b0};

    assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1) |=> status_byte[1]);

    assert_wel_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4)) |=> !status_byte[1]);

    assert_no_grant_unlatched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_write_ok || mem_write_ok) |-> status_byte[1]);

    assert_full_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !mem_write_ok);

    assert_hw_sr_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[7] && !wp_n) |-> !sr_write_ok);

    assert_prot_en_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[7] && !wp_n) |=> status_byte[7]);

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(status_byte));

    assert_fixed_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[6:4] == 3'b000) && !status_byte[0]);
endmodule

// File: tb/test_wprot_unit.sv
`timescale 1ns/1ps
module test_wprot_unit;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = 8'h00;
    logic          wp_n = 1'b1;
    logic          sr_write_ok, mem_write_ok;
    logic [7:0]    status_byte;

    always #2.5 clk = ~clk;

    wprot_unit #(.ADDR_W(AW), .BP_INIT(2'b01), .WPEN_INIT(1'b0)) i_wprot_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
        .sr_write_ok(sr_write_ok), .mem_write_ok(mem_write_ok),
        .status_byte(status_byte)
    );

    int total = 0;
    int bad = 0;

    logic       m_wel;
    logic       m_pen;
    logic [1:0] m_lvl;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic bit seg_locked(input logic [1:0] lvl, input int a);
        int q;
        q = (lvl == 2'd3) ? 4 : int'(lvl);
        return a >= (4 - q) * (1 << (AW - 2));
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_pen, 3'b000, m_lvl, m_wel, 1'b0};
    endfunction

    task automatic cmd(input logic [2:0] op, input int a, input logic [7:0] d, input logic vld);
        logic sro, mo, exp_sr, exp_mem, hw;
        string lbl;
        @(negedge clk);
        cmd_valid = vld; cmd_op = op; cmd_addr = AW'(a); cmd_data = d;
        #1;
        sro = sr_write_ok; mo = mem_write_ok;
        hw = m_pen && !wp_n;
        exp_sr  = vld && op == 3'd3 && m_wel && !hw;
        exp_mem = vld && op == 3'd4 && m_wel && !seg_locked(m_lvl, a);
        if (!vld || op == 3'd0 || op > 3'd4) lbl = "R10";
        else if (!m_wel) lbl = "R4";
        else if (op == 3'd3) lbl = hw ? "R6" : "R8";
        else lbl = hw ? "R7" : "R5";
        check({lbl, " sr_grant"}, sro, exp_sr);
        check({lbl, " mem_grant"}, mo, exp_mem);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        if (vld) begin
            if (op == 3'd1) m_wel = 1'b1;
            if (op == 3'd2 || op == 3'd3 || op == 3'd4) m_wel = 1'b0;
            if (exp_sr) begin
                m_pen = d[7];
                m_lvl = d[3:2];
            end
        end
        if (vld && (op == 3'd3 || op == 3'd4)) lbl = "R3";
        else if (vld && (op == 3'd1 || op == 3'd2)) lbl = "R2";
        else lbl = "R10";
        check({lbl, " status"}, status_byte, exp_status());
    endtask

    task automatic set_state(input logic pen, input logic [1:0] lvl);
        wp_n = 1'b1;
        cmd(3'd1, 0, 8'h00, 1'b1);
        cmd(3'd3, 0, {pen, 3'b111, lvl, 2'b11}, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_wel = 1'b0; m_pen = 1'b0; m_lvl = 2'b01;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset status", status_byte, 8'h04);
        check("R11 zero bits", {status_byte[6:4], status_byte[0]}, 0);
        rst_n = 1'b1;

        cmd(3'd4, 0, 8'h00, 1'b1);
        cmd(3'd3, 0, 8'h8c, 1'b1);

        cmd(3'd1, 0, 8'h00, 1'b0);
        cmd(3'd1, 0, 8'h00, 1'b1);
        cmd(3'd5, 0, 8'hff, 1'b1);
        cmd(3'd7, 0, 8'hff, 1'b1);
        cmd(3'd0, 0, 8'hff, 1'b1);
        check("R2 latch held", status_byte[1], 1);
        cmd(3'd2, 0, 8'h00, 1'b1);
        check("R2 latch cleared", status_byte[1], 0);

        for (int pen = 0; pen < 2; pen++)
            for (int lvl = 0; lvl < 4; lvl++)
                for (int wp = 0; wp < 2; wp++)
                    for (int wl = 0; wl < 2; wl++)
                        for (int seg = 0; seg < 4; seg++)
                            for (int edge_i = 0; edge_i < 2; edge_i++) begin
                                set_state(pen[0], lvl[1:0]);
                                wp_n = wp[0];
                                cmd(wl[0] ? 3'd1 : 3'd2, 0, 8'h00, 1'b1);
                                cmd(3'd4, seg * (1 << (AW - 2)) + edge_i * ((1 << (AW - 2)) - 1),
                                    8'h00, 1'b1);
                            end

        for (int pen = 0; pen < 2; pen++)
            for (int wp = 0; wp < 2; wp++)
                for (int wl = 0; wl < 2; wl++) begin
                    set_state(pen[0], 2'b10);
                    wp_n = wp[0];
                    cmd(wl[0] ? 3'd1 : 3'd2, 0, 8'h00, 1'b1);
                    cmd(3'd3, 0, {~pen[0], 3'b000, 2'b01, 2'b00}, 1'b1);
                end

        set_state(1'b1, 2'b00);
        wp_n = 1'b0;
        cmd(3'd1, 0, 8'h00, 1'b1);
        cmd(3'd3, 0, 8'h00, 1'b1);
        check("R9 prot_en kept while pin low", status_byte[7], 1);
        wp_n = 1'b1;
        cmd(3'd1, 0, 8'h00, 1'b1);
        cmd(3'd3, 0, 8'h00, 1'b1);
        check("R9 prot_en cleared after pin high", status_byte[7], 0);

        set_state(1'b1, 2'b00);
        cmd(3'd1, 0, 8'h00, 1'b1);
        wp_n = 1'b0;
        cmd(3'd3, 0, 8'h0c, 1'b1);
        check("R6 same-cycle pin drop level", status_byte[3:2], 0);
        cmd(3'd1, 0, 8'h00, 1'b1);
        wp_n = 1'b1;
        cmd(3'd3, 0, 8'h74, 1'b1);
        check("R8 loaded bits only", status_byte, 8'h04);
        check("R11 final zero bits", {status_byte[6:4], status_byte[0]}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule